// File: doc/BRIEF.md
# Last-Round Leakage Hypothesis Generator

This block produces one predicted power value for a correlation attack on the final round of a 128-bit block cipher with a byte-wise substitution layer. It receives a whole ciphertext block, a guessed last-round key byte and the index of the state byte under study. It picks the ciphertext byte that the target state byte was moved to by the final row rotation. It strips the guessed key from that byte and applies the inverse substitution box, which gives back the value the state register held before the last round.

The block then scores the register transition from that recovered byte to the ciphertext byte that finally occupies the same register position. A two-bit mode input selects the leakage model. The first counts the set bits of the recovered byte. The second counts the bits that differ. The third counts rising and falling bits with unequal weights, on a doubled fixed-point scale, so that a falling weight of one and a half stays an integer.

An analysis engine feeds one guess per cycle and collects the predictions two cycles later.

Top module: `leak_hypo_gen`

## Requirements
- R1: After reset, `out_valid` is low. Every accepted `in_valid` beat gives exactly one `out_valid` beat two clock cycles later, and no other beat appears.
- R2: `pos` names a state byte in column-major order: row = `pos[1:0]`, column = `pos[3:2]`. Ciphertext byte i sits at `ct[8*i+7:8*i]`. The recovery source is the byte at row = row, column = (column − row) mod 4. The transition target is the ciphertext byte at `pos` itself.
- R3: `round_in` equals the inverse substitution box applied to (source byte XOR `key_guess`). Examples: 0x63 maps to 0x00, 0x00 maps to 0x52 and 0x16 maps to 0xFF. Every one of the 256 key guesses is accepted.
- R4: With mode 2'b00, `pred` is the number of set bits in the recovered byte.
- R5: With mode 2'b01, `pred` is the number of bit positions in which the recovered byte and the target byte differ.
- R6: With mode 2'b10, `pred` is 2 × (bits that are 0 in the recovered byte and 1 in the target byte) + 3 × (bits that are 1 in the recovered byte and 0 in the target byte). This is twice the model value with a falling weight of 1.5. Equal bytes give 0.
- R7: Mode 2'b11 is reserved. It still produces a valid beat, with `pred` equal to 0.
- R8: `pred` never exceeds 24. While `out_valid` is low, both `pred` and `round_in` are 0.
- R9: Inputs may arrive on consecutive cycles with any mix of modes and positions. Results leave in input order, and each result uses the mode and position of its own beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat qualifier |
| ct | input | 128 | Ciphertext block, byte i at bits 8i+7..8i |
| key_guess | input | 8 | Guessed last-round key byte |
| pos | input | 4 | Target state byte index (row in bits 1:0, column in bits 3:2) |
| mode | input | 2 | Leakage model: 00 weight, 01 distance, 10 asymmetric, 11 reserved |
| out_valid | output | 1 | Prediction qualifier |
| pred | output | 5 | Predicted power value |
| round_in | output | 8 | Recovered pre-round state byte |

## Verification
The assertions assume that `in_valid` is a defined level on every clock after reset, because the valid pipeline and the zeroing of idle outputs follow it directly. They also assume that `mode` is sampled only on valid beats, so the reserved-mode and bound checks are conditioned on the registered valid bit. The bench respects both assumptions: it drives every input at the falling edge, holds `in_valid` low through reset, and randomises `ct`, `key_guess`, `pos` and `mode` freely on both valid and idle beats. This shows that idle-beat data never reaches the outputs.

// File: rtl/lhg_pkg.sv
package lhg_pkg;

    localparam int BYTE_W   = 8;
    localparam int ROWS     = 4;
    localparam int COLS     = 4;
    localparam int N_BYTES  = ROWS * COLS;
    localparam int POS_W    = $clog2(N_BYTES);
    localparam int ROW_W    = $clog2(ROWS);
    localparam int CT_W     = N_BYTES * BYTE_W;
    localparam int CNT_W    = $clog2(BYTE_W + 1);
    localparam int RISE_WT  = 2;
    localparam int FALL_WT  = 3;
    localparam int PRED_MAX = FALL_WT * BYTE_W;
    localparam int PRED_W   = $clog2(PRED_MAX + 1);

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        LM_WEIGHT = 2'b00,
        LM_DIST   = 2'b01,
        LM_SWITCH = 2'b10,
        LM_RSV    = 2'b11
    } lmode_e;

    typedef struct packed {
        logic   valid;
        lmode_e mode;
        byte_t  rec;
        byte_t  tgt;
    } stage_t;

    function automatic byte_t rotl(input byte_t v, input int n);
        return byte_t'((v << n) | (v >> (BYTE_W - n)));
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t aa;
        acc = '0;
        aa  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ aa;
            aa = aa[7] ? byte_t'((aa << 1) ^ 8'h1b) : byte_t'(aa << 1);
        end
        return acc;
    endfunction

    // multiplicative inverse as x^254; zero maps to zero
    function automatic byte_t gf_inv(input byte_t x);
        byte_t r;
        byte_t p;
        r = 8'h01;
        p = x;
        for (int i = 0; i < BYTE_W; i++) begin
            if (i != 0) r = gf_mul(r, p);
            p = gf_mul(p, p);
        end
        return r;
    endfunction

    function automatic byte_t inv_sub(input byte_t y);
        byte_t t;
        t = rotl(y, 1) ^ rotl(y, 3) ^ rotl(y, 6) ^ 8'h05;
        return gf_inv(t);
    endfunction

    function automatic logic [CNT_W-1:0] ones(input byte_t v);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < BYTE_W; i++) n = n + CNT_W'(v[i]);
        return n;
    endfunction

endpackage

// File: rtl/lhg_remap.sv
module lhg_remap
    import lhg_pkg::*;
(
    input  logic [CT_W-1:0]  ct,
    input  logic [POS_W-1:0] pos,
    output byte_t            src_byte,
    output byte_t            tgt_byte
);
    localparam int COL_W = POS_W - ROW_W;

    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    logic [COL_W-1:0] src_col;
    logic [POS_W-1:0] src_idx;

    always_comb begin
        row      = pos[ROW_W-1:0];
        col      = pos[POS_W-1:ROW_W];
        // forward rotation moved row r left by r; undo by stepping back r columns
        src_col  = col - COL_W'(row);
        src_idx  = {src_col, row};
        src_byte = ct[BYTE_W*src_idx +: BYTE_W];
        tgt_byte = ct[BYTE_W*pos +: BYTE_W];
    end

endmodule

// File: rtl/lhg_unround.sv
module lhg_unround
    import lhg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  lmode_e mode,
    input  byte_t  src_byte,
    input  byte_t  tgt_byte,
    input  byte_t  key_guess,
    output stage_t s1
);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.valid <= in_valid;
            s1.mode  <= mode;
            s1.rec   <= inv_sub(src_byte ^ key_guess);
            s1.tgt   <= tgt_byte;
        end
    end

    assert_stage_fill_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> s1.valid);
    assert_stage_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !s1.valid);

endmodule

// File: rtl/lhg_score.sv
module lhg_score
    import lhg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  stage_t            s1,
    output logic              out_valid,
    output logic [PRED_W-1:0] pred,
    output byte_t             round_in
);
    localparam logic [PRED_W-1:0] W_RISE = PRED_W'(RISE_WT);
    localparam logic [PRED_W-1:0] W_FALL = PRED_W'(FALL_WT);

    logic [CNT_W-1:0]  n_set, n_diff, n_rise, n_fall;
    logic [PRED_W-1:0] score;

    always_comb begin
        n_set  = ones(s1.rec);
        n_diff = ones(s1.rec ^ s1.tgt);
        n_rise = ones(~s1.rec & s1.tgt);
        n_fall = ones(s1.rec & ~s1.tgt);
        unique case (s1.mode)
            LM_WEIGHT: score = PRED_W'(n_set);
            LM_DIST:   score = PRED_W'(n_diff);
            LM_SWITCH: score = W_RISE * PRED_W'(n_rise) + W_FALL * PRED_W'(n_fall);
            default:   score = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            pred      <= '0;
            round_in  <= '0;
        end else begin
            out_valid <= s1.valid;
            pred      <= s1.valid ? score : '0;
            round_in  <= s1.valid ? s1.rec : '0;
        end
    end

    assert_out_follow_R1: assert property (@(posedge clk) disable iff (rst)
        s1.valid |=> out_valid);
    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (s1.valid && s1.mode == LM_RSV) |=> (out_valid && pred == '0));
    assert_weight_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (s1.valid && s1.mode == LM_WEIGHT) |=> pred <= PRED_W'(BYTE_W));
    assert_dist_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (s1.valid && s1.mode == LM_DIST) |=> pred <= PRED_W'(BYTE_W));
    assert_equal_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (s1.valid && s1.mode == LM_SWITCH && s1.rec == s1.tgt) |=> pred == '0);
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        pred <= PRED_W'(PRED_MAX));
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (pred == '0 && round_in == '0));

endmodule

// File: rtl/leak_hypo_gen.sv
module leak_hypo_gen
    import lhg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CT_W-1:0]   ct,
    input  logic [7:0]        key_guess,
    input  logic [POS_W-1:0]  pos,
    input  logic [1:0]        mode,
    output logic              out_valid,
    output logic [PRED_W-1:0] pred,
    output logic [7:0]        round_in
);
    byte_t  src_byte, tgt_byte;
    stage_t s1;
    lmode_e mode_e;

    assign mode_e = lmode_e'(mode);

    lhg_remap u_remap (
        .ct       (ct),
        .pos      (pos),
        .src_byte (src_byte),
        .tgt_byte (tgt_byte)
    );

    lhg_unround u_unround (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .mode      (mode_e),
        .src_byte  (src_byte),
        .tgt_byte  (tgt_byte),
        .key_guess (key_guess),
        .s1        (s1)
    );

    lhg_score u_score (
        .clk       (clk),
        .rst       (rst),
        .s1        (s1),
        .out_valid (out_valid),
        .pred      (pred),
        .round_in  (round_in)
    );

endmodule

// File: tb/leak_hypo_gen_test.sv
module leak_hypo_gen_test;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] ct;
    logic [7:0]   key_guess;
    logic [3:0]   pos;
    logic [1:0]   mode;
    logic         out_valid;
    logic [4:0]   pred;
    logic [7:0]   round_in;

    always #5 clk = ~clk;

    leak_hypo_gen uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .ct(ct),
        .key_guess(key_guess), .pos(pos), .mode(mode),
        .out_valid(out_valid), .pred(pred), .round_in(round_in)
    );

    int checks = 0;
    int fails  = 0;
    int sbox_fwd [256];
    int sbox_inv [256];

    typedef struct { int v; int p; int r; string tag; } exp_t;
    exp_t expq[$];

    function automatic int gmul(int a, int b);
        int acc = 0;
        for (int i = 0; i < 8; i++) begin
            if ((b >> i) & 1) acc ^= a;
            a = (a << 1) ^ (((a >> 7) & 1) ? 'h11b : 0);
        end
        return acc & 'hff;
    endfunction

    function automatic int rl(int v, int n);
        return ((v << n) | (v >> (8 - n))) & 'hff;
    endfunction

    function automatic int popc(int v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (v >> i) & 1;
        return n;
    endfunction

    task automatic build_tables();
        for (int x = 0; x < 256; x++) begin
            int iv = 0;
            for (int y = 1; y < 256; y++) if (gmul(x, y) == 1) iv = y;
            sbox_fwd[x] = iv ^ rl(iv, 1) ^ rl(iv, 2) ^ rl(iv, 3) ^ rl(iv, 4) ^ 'h63;
        end
        for (int x = 0; x < 256; x++) sbox_inv[sbox_fwd[x]] = x;
    endtask

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h) at %0t",
                     tag, act, act, exp, exp, $time);
        end
    endtask

    task automatic compare_front();
        exp_t e = expq.pop_front();
        check("R1 out_valid", int'(out_valid), e.v);
        check({e.tag, " pred"}, int'(pred), e.p);
        check("R3 round_in", int'(round_in), e.r);
    endtask

    task automatic step(bit v, logic [127:0] c, logic [7:0] k, logic [3:0] p, logic [1:0] m);
        exp_t e;
        @(negedge clk);
        compare_front();
        in_valid = v; ct = c; key_guess = k; pos = p; mode = m;
        if (!v) begin
            e = '{0, 0, 0, "R8 idle"};
        end else begin
            int row = p % 4;
            int col = p / 4;
            int src = 4 * ((col - row + 4) % 4) + row;   // R2 remap
            int sb  = int'(c[8*src +: 8]);
            int tb  = int'(c[8*p +: 8]);
            int d   = sbox_inv[sb ^ int'(k)];
            int rise = popc(~d & tb & 'hff);
            int fall = popc(d & ~tb & 'hff);
            e.v = 1; e.r = d;
            case (m)
                2'b00: begin e.p = popc(d);                 e.tag = "R4 weight"; end
                2'b01: begin e.p = popc(d ^ tb);            e.tag = "R5 distance"; end
                2'b10: begin e.p = 2 * rise + 3 * fall;     e.tag = "R6 switching"; end
                default: begin e.p = 0;                     e.tag = "R7 reserved"; end
            endcase
        end
        expq.push_back(e);
    endtask

    function automatic logic [127:0] rnd_ct();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        #(10 * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [127:0] c;
        build_tables();
        // bench table sanity against known R3 values
        check("R3 table 63", sbox_inv['h63], 'h00);
        check("R3 table 00", sbox_inv['h00], 'h52);
        check("R3 table 16", sbox_inv['h16], 'hff);

        rst = 1'b1; in_valid = 1'b0; ct = '0; key_guess = '0; pos = '0; mode = '0;
        repeat (3) @(negedge clk);
        check("R1 reset out_valid", int'(out_valid), 0);
        check("R8 reset pred", int'(pred), 0);
        check("R8 reset round_in", int'(round_in), 0);
        rst = 1'b0;
        expq.push_back('{0, 0, 0, "R8 idle"});
        expq.push_back('{0, 0, 0, "R8 idle"});

        // R3 known values through position 0 (row 0, no remap)
        c = '0; c[7:0] = 8'h63;
        step(1, c, 8'h00, 4'd0, 2'b00);
        step(1, c, 8'h63, 4'd0, 2'b00);

        // R6 extremes: pos 5 (row 1, col 1) recovers from byte 1
        c = '0; c[15:8] = 8'h16; c[47:40] = 8'h00;
        step(1, c, 8'h00, 4'd5, 2'b10);   // all fall: 24
        c[15:8] = 8'h63; c[47:40] = 8'hff;
        step(1, c, 8'h00, 4'd5, 2'b10);   // all rise: 16
        step(1, c, 8'h00, 4'd5, 2'b11);   // R7 reserved
        c[47:40] = 8'h00;
        step(1, c, 8'h00, 4'd5, 2'b10);   // equal: 0

        // R2: distinct bytes, every position, every mode
        for (int i = 0; i < 16; i++) c[8*i +: 8] = 8'(i * 17 + 1);
        for (int m = 0; m < 4; m++)
            for (int p = 0; p < 16; p++)
                step(1, c, 8'h5a, 4'(p), 2'(m));

        // R3: sweep all 256 key guesses on one position
        c = rnd_ct();
        for (int k = 0; k < 256; k++) step(1, c, 8'(k), 4'd6, 2'b10);

        // R9 and R8: random mix with idle gaps carrying junk data
        for (int n = 0; n < 1500; n++)
            step(($urandom() % 4) != 0, rnd_ct(), 8'($urandom()),
                 4'($urandom()), 2'($urandom()));

        repeat (3) step(0, '0, '0, '0, '0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule